// File: doc/BRIEF.md
# Hashed Presence Gate for Load/Store Queue Searches

This block sits beside a load/store queue and decides, for each disambiguation check, whether the costly associative address compare over the queue has to run at all. Each memory operation that enters the queue is hashed to one position of a presence filter, and that position is marked. When an operation later asks whether any queued operation may share its address, the block tests the position its own address hashes to. An unmarked position proves there is no match, so the check is answered at once. A marked position means the associative compare must run. Two addresses that share a position can make a search find nothing, which only costs energy. A real match is never skipped.

Each filter position is a small saturating counter, not a single bit. Operations leaving the queue decrement their position, so the filter does not fill up with stale marks. Once a counter saturates, it can no longer tell how many operations it stands for. It then stays marked until a flush. A flush, issued on a pipeline squash, empties the whole filter in one cycle. Two running counts, one for filtered answers and one for searched answers, let the filtering rate be measured.

Top module: `lsq_search_gate`

## Requirements
- R1: The filter index of an address is the XOR of the word address (the bits from OFF_W upward) cut into IDX_W-bit chunks, with the lowest chunk starting at bit OFF_W and the top chunk padded with zeros.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `qry_valid` high, and low otherwise.
- R3: A query whose index counter is zero, with no insert to that index in the same cycle, answers `rsp_search` = 0 (filtered).
- R4: A query to the address of any operation that has been inserted and not yet removed answers `rsp_search` = 1 (search), so there are no false negatives.
- R5: A remove decrements the counter of its index. After every insert to an index has been matched by a remove, queries to that index are filtered again.
- R6: Counters saturate at 2^CNT_W-1. An insert at the maximum leaves the counter unchanged, and a remove never decrements a saturated counter, so its index answers search until a flush.
- R7: An insert and a query to the same index in the same cycle answer search. An insert and a remove to the same index in the same cycle leave that counter unchanged.
- R8: A flush clears every counter in one cycle and overrides an insert or remove in the same cycle. A query in the flush cycle is answered from the state before the flush.
- R9: `filtered_count` and `searched_count` increase by one for each filtered or searched answer, in the same cycle as the answer. They wrap at 2^STAT_W and are not cleared by a flush.
- R10: After reset, every counter is zero, `rsp_valid` is low, and both counts are zero.
- R11: A remove to an index whose counter is zero is ignored: the counter does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An operation enters the queue |
| ins_addr | input | ADDR_W | Address of the entering operation |
| rem_valid | input | 1 | An operation leaves the queue |
| rem_addr | input | ADDR_W | Address of the leaving operation |
| qry_valid | input | 1 | Disambiguation check request |
| qry_addr | input | ADDR_W | Address to check |
| flush | input | 1 | Clear the whole filter |
| rsp_valid | output | 1 | Answer to the previous cycle's check |
| rsp_search | output | 1 | 1: run the associative compare, 0: no match possible |
| filtered_count | output | STAT_W | Number of filtered answers |
| searched_count | output | STAT_W | Number of searched answers |

## Verification
The assertions assume that a remove only names an operation that is still in the queue. Removing an absent address whose hash aliases a live entry would lower that entry's counter and break the guarantee against false negatives. The randomized phase of the bench removes only addresses it holds on its own list of live operations. The single deliberate remove on an empty filter targets a counter that is already zero, so the assumption still holds there.

// File: rtl/lsq_gate_pkg.sv
package lsq_gate_pkg;
  // number of IDX_W-wide chunks needed to cover a word address
  function automatic int fold_chunks(input int src_w, input int idx_w);
    return (src_w + idx_w - 1) / idx_w;
  endfunction
endpackage

// File: rtl/lsq_gate_hash.sv
module lsq_gate_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int SRC_W = ADDR_W - OFF_W;
  localparam int NCH   = lsq_gate_pkg::fold_chunks(SRC_W, IDX_W);
  localparam int PAD_W = NCH * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] acc;

  assign padded = PAD_W'(addr[ADDR_W-1:OFF_W]);

  always_comb begin
    acc = '0;
    for (int c = 0; c < NCH; c++) acc = acc ^ padded[c*IDX_W +: IDX_W];
  end

  assign idx = acc;
endmodule

// File: rtl/lsq_gate_cntbank.sv
module lsq_gate_cntbank #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    inc_en,
  input  logic [IDX_W-1:0]        inc_idx,
  input  logic                    dec_en,
  input  logic [IDX_W-1:0]        dec_idx,
  output logic [(1<<IDX_W)-1:0]   occupied
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [CNT_W-1:0] cnt;
    logic inc, dec;
    assign inc = inc_en && (inc_idx == IDX_W'(g));
    assign dec = dec_en && (dec_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        cnt <= '0;
      end else if (inc && !dec) begin
        if (cnt != CMAX) cnt <= cnt + 1'b1;
      end else if (dec && !inc) begin
        if (cnt != CMAX && cnt != '0) cnt <= cnt - 1'b1;
      end
    end

    assign occupied[g] = (cnt != '0);
  end
endmodule

// File: rtl/lsq_gate_resp.sv
module lsq_gate_resp #(
  parameter int IDX_W  = 6,
  parameter int STAT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  qry_valid,
  input  logic [IDX_W-1:0]      qry_idx,
  input  logic                  ins_valid,
  input  logic [IDX_W-1:0]      ins_idx,
  input  logic [(1<<IDX_W)-1:0] occupied,
  output logic                  rsp_valid,
  output logic                  rsp_search,
  output logic [STAT_W-1:0]     filtered_count,
  output logic [STAT_W-1:0]     searched_count
);
  logic hit;
  assign hit = occupied[qry_idx] || (ins_valid && (ins_idx == qry_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_search     <= 1'b0;
      filtered_count <= '0;
      searched_count <= '0;
    end else begin
      rsp_valid  <= qry_valid;
      rsp_search <= qry_valid && hit;
      if (qry_valid && hit)  searched_count <= searched_count + 1'b1;
      if (qry_valid && !hit) filtered_count <= filtered_count + 1'b1;
    end
  end
endmodule

// File: rtl/lsq_search_gate.sv
module lsq_search_gate #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 2,
  parameter int OFF_W  = 2,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              rem_valid,
  input  logic [ADDR_W-1:0] rem_addr,
  input  logic              qry_valid,
  input  logic [ADDR_W-1:0] qry_addr,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_search,
  output logic [STAT_W-1:0] filtered_count,
  output logic [STAT_W-1:0] searched_count
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]   i_idx, r_idx, q_idx;
  logic [ENTRIES-1:0] occ;

  lsq_gate_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_hash_ins (.addr(ins_addr), .idx(i_idx));
  lsq_gate_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_hash_rem (.addr(rem_addr), .idx(r_idx));
  lsq_gate_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_hash_qry (.addr(qry_addr), .idx(q_idx));

  lsq_gate_cntbank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .flush(flush),
    .inc_en(ins_valid), .inc_idx(i_idx),
    .dec_en(rem_valid), .dec_idx(r_idx),
    .occupied(occ)
  );

  lsq_gate_resp #(.IDX_W(IDX_W), .STAT_W(STAT_W)) u_resp (
    .clk(clk), .rst(rst),
    .qry_valid(qry_valid), .qry_idx(q_idx),
    .ins_valid(ins_valid), .ins_idx(i_idx),
    .occupied(occ),
    .rsp_valid(rsp_valid), .rsp_search(rsp_search),
    .filtered_count(filtered_count), .searched_count(searched_count)
  );
endmodule

// File: rtl/lsq_search_gate_chk.sv
module lsq_search_gate_chk #(
  parameter int IDX_W  = 6,
  parameter int STAT_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  qry_valid,
  input logic                  ins_valid,
  input logic                  flush,
  input logic [IDX_W-1:0]      qry_idx,
  input logic [IDX_W-1:0]      ins_idx,
  input logic [(1<<IDX_W)-1:0] occupied,
  input logic                  rsp_valid,
  input logic                  rsp_search,
  input logic [STAT_W-1:0]     filtered_count,
  input logic [STAT_W-1:0]     searched_count
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> !rsp_valid);
  assert_bypass_insert_R7: assert property (@(posedge clk) disable iff (rst)
    (qry_valid && ins_valid && ins_idx == qry_idx) |=> rsp_search);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occupied == '0));
  assert_empty_filters_R3: assert property (@(posedge clk) disable iff (rst)
    (qry_valid && !occupied[qry_idx] && !(ins_valid && ins_idx == qry_idx)) |=> !rsp_search);
  assert_search_count_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_search) |-> searched_count == STAT_W'($past(searched_count) + 1'b1));
  assert_filter_count_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_search) |-> filtered_count == STAT_W'($past(filtered_count) + 1'b1));
  assert_search_only_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_search |-> rsp_valid);
endmodule

bind lsq_search_gate lsq_search_gate_chk #(.IDX_W(IDX_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .qry_valid(qry_valid), .ins_valid(ins_valid), .flush(flush),
  .qry_idx(q_idx), .ins_idx(i_idx), .occupied(occ),
  .rsp_valid(rsp_valid), .rsp_search(rsp_search),
  .filtered_count(filtered_count), .searched_count(searched_count)
);

// File: tb/lsq_search_gate_bench.sv
`timescale 1ns/1ps
module lsq_search_gate_bench;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = 2;
  localparam int OFF_W  = 2;
  localparam int STAT_W = 16;
  localparam int NIDX   = 1 << IDX_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0, rem_valid = 1'b0, qry_valid = 1'b0, flush = 1'b0;
  logic [ADDR_W-1:0] ins_addr = '0, rem_addr = '0, qry_addr = '0;
  logic rsp_valid, rsp_search;
  logic [STAT_W-1:0] filtered_count, searched_count;

  always #4 clk = ~clk;

  lsq_search_gate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .STAT_W(STAT_W)) u_lsq_search_gate (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_addr(ins_addr),
    .rem_valid(rem_valid), .rem_addr(rem_addr),
    .qry_valid(qry_valid), .qry_addr(qry_addr),
    .flush(flush),
    .rsp_valid(rsp_valid), .rsp_search(rsp_search),
    .filtered_count(filtered_count), .searched_count(searched_count)
  );

  int checks = 0, errors = 0;
  int model [NIDX];
  int exp_filt = 0, exp_srch = 0;
  bit done = 0;

  function automatic int hidx(input int a);
    int s = (a & ((1 << ADDR_W) - 1)) >> OFF_W;
    int r = 0;
    while (s != 0) begin
      r = r ^ (s & (NIDX - 1));
      s = s >> IDX_W;
    end
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock of stimulus; checks the answer when a query was issued
  task automatic step(input bit i, input int ia, input bit r, input int ra,
                      input bit q, input int qa, input bit f, input string tag);
    int qi = hidx(qa), ii = hidx(ia), ri = hidx(ra);
    int exp = (model[qi] != 0 || (i && ii == qi)) ? 1 : 0;
    ins_valid = i; ins_addr = ADDR_W'(ia);
    rem_valid = r; rem_addr = ADDR_W'(ra);
    qry_valid = q; qry_addr = ADDR_W'(qa);
    flush = f;
    if (f) begin
      for (int k = 0; k < NIDX; k++) model[k] = 0;
    end else if (i && r && ii == ri) begin
      // net zero
    end else begin
      if (i && model[ii] != CMAX) model[ii]++;
      if (r && model[ri] != CMAX && model[ri] != 0) model[ri]--;
    end
    if (q) begin
      if (exp != 0) exp_srch++; else exp_filt++;
    end
    @(negedge clk);
    ins_valid = 0; rem_valid = 0; qry_valid = 0; flush = 0;
    check({tag, " rsp_valid"}, int'(rsp_valid), int'(q));
    if (q) check({tag, " rsp_search"}, int'(rsp_search), exp);
  endtask

  task automatic query(input int a, input string tag);
    step(0, 0, 0, 0, 1, a, 0, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int lf;
    int live [16];
    int nlive;
    for (int k = 0; k < NIDX; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 rsp_valid", int'(rsp_valid), 0);
    check("R10 filtered_count", int'(filtered_count), 0);
    check("R10 searched_count", int'(searched_count), 0);

    // R3 every address filtered on an empty filter
    for (int a = 0; a < (1 << ADDR_W); a++) query(a, "R3 empty sweep");
    step(0, 0, 0, 0, 0, 0, 0, "R2 idle");

    // R1 R4 one live entry: search exactly where the folded index matches
    step(1, 'h5A4, 0, 0, 0, 0, 0, "R4 insert");
    for (int a = 0; a < (1 << ADDR_W); a++) query(a, "R1 R4 single entry sweep");
    // R5 remove returns to filtered
    step(0, 0, 1, 'h5A4, 0, 0, 0, "R5 remove");
    for (int a = 0; a < (1 << ADDR_W); a += 4) query(a, "R5 after remove");
    // R5 two inserts need two removes
    step(1, 'h124, 0, 0, 0, 0, 0, "R5 ins a");
    step(1, 'h124, 0, 0, 0, 0, 0, "R5 ins b");
    step(0, 0, 1, 'h124, 1, 'h124, 0, "R5 one removed still search");
    step(0, 0, 1, 'h124, 0, 0, 0, "R5 second remove");
    query('h124, "R5 both removed");

    // R6 saturation is sticky
    for (int k = 0; k < 5; k++) step(1, 'h3F0, 0, 0, 0, 0, 0, "R6 ins");
    for (int k = 0; k < 5; k++) step(0, 0, 1, 'h3F0, 0, 0, 0, "R6 rem");
    query('h3F0, "R6 saturated stays");
    query('h3F4, "R6 other index");

    // R8 flush, and flush wins over same-cycle insert; query in flush cycle sees old state
    step(1, 'h088, 0, 0, 1, 'h3F0, 1, "R8 flush cycle query");
    query('h3F0, "R8 after flush");
    query('h088, "R8 flush beats insert");

    // R7 same-cycle insert and query
    step(1, 'h200, 0, 0, 1, 'h200, 0, "R7 bypass same addr");
    step(1, 'h010, 0, 0, 1, 'h010 ^ ('h3 << (OFF_W + IDX_W)) ^ ('h3 << OFF_W), 0, "R7 bypass aliased addr");
    step(1, 'h600, 1, 'h600, 1, 'h604, 0, "R7 ins rem same idx");
    query('h600, "R7 ins rem net zero");
    step(0, 0, 0, 0, 0, 0, 1, "R8 flush");

    // R11 remove on zero is ignored
    step(0, 0, 1, 'h0C0, 0, 0, 0, "R11 remove empty");
    step(1, 'h0C0, 0, 0, 0, 0, 0, "R11 ins");
    step(0, 0, 1, 'h0C0, 0, 0, 0, "R11 rem");
    query('h0C0, "R11 no wrap");

    // R9 counters before random phase
    check("R9 filtered_count", int'(filtered_count), exp_filt & 'hFFFF);
    check("R9 searched_count", int'(searched_count), exp_srch & 'hFFFF);

    // R4 random mix, removes only of live operations
    step(0, 0, 0, 0, 0, 0, 1, "R8 flush");
    lf = 'hACE1;
    nlive = 0;
    for (int n = 0; n < 3000; n++) begin
      int op, ad, k;
      bit di, dr, dq;
      int ia, ra, qa;
      lf = ((lf >> 1) ^ (-(lf & 1) & 'hB400)) & 'hFFFF;
      op = lf & 7; ad = (lf >> 3) & 'hFFF;
      di = 0; dr = 0; dq = 1; ia = 0; ra = 0; qa = ad;
      if (op < 3 && nlive < 16) begin
        di = 1; ia = ad; live[nlive] = ad; nlive++;
      end else if (op < 5 && nlive > 0) begin
        k = ad % nlive; dr = 1; ra = live[k]; live[k] = live[nlive-1]; nlive--;
      end
      if (((lf >> 7) & 1) && nlive > 0) qa = live[(lf >> 8) % nlive];
      step(di, ia, dr, ra, dq, qa, 0, "R4 random mix");
    end
    check("R9 filtered_count end", int'(filtered_count), exp_filt & 'hFFFF);
    check("R9 searched_count end", int'(searched_count), exp_srch & 'hFFFF);
    done = 1;
    finish_run();
  end
endmodule